// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block picks the two ALU operands for the instruction in the execute stage of a five-stage integer pipeline. Each operand has a four-way multiplexer. One input is the value read from the register file. The other three are bypass paths: the ALU result held in the execute/memory pipeline register, the ALU result held in the memory/writeback register, and the loaded data held in the memory/writeback register.

The unit reads three instruction words: the consumer in the decode/execute register and the two older producers. For each producer it works out whether that producer writes a register, and which field holds the destination. It then compares that destination with the consumer's source fields. It drives one 2-bit select per operand, and the multiplexed operand values for the ALU. The logic is purely combinational and holds no state.

A producer that sits three slots ahead needs no bypass. The register file is written in the first half of a cycle and read in the second half, so the register-file value is already current. Stall insertion for a load followed directly by a user is handled outside this block.

Top module: `fwd_unit_top`

## Requirements
- R1: Bits are numbered big-endian within a 32-bit instruction word, so bit 0 is the MSB. Opcode is bits 0..5 (word[31:26]), first source bits 6..10 (word[25:21]), second source or immediate-form destination bits 11..15 (word[20:16]), register-register destination bits 16..20 (word[15:11]). Opcode classes: 0x00 register-register ALU, 0x08..0x0F ALU immediate, 0x23 load, 0x2B store, 0x04/0x05 branch; every other opcode writes and reads nothing.
- R2: Operand A select is 01 (EX/MEM ALU result) when the EX/MEM instruction is an ALU producer, its destination is nonzero and equals the consumer's first source, and the consumer has a known opcode.
- R3: A register-register producer's destination is taken from bits 16..20. Load and immediate producers take theirs from bits 11..15.
- R4: If EX/MEM does not apply, the select is 10 (MEM/WB ALU result) when the MEM/WB instruction is an ALU producer whose nonzero destination matches the source.
- R5: If EX/MEM does not apply, the select is 11 (MEM/WB load data) when the MEM/WB instruction is a load whose nonzero destination matches the source.
- R6: When both producers match the same source, EX/MEM wins.
- R7: Operand B compares the consumer's bits 11..15 and forwards only when the consumer is register-register; for any other consumer its select is 00.
- R8: A destination of register 0 never forwards.
- R9: Stores, branches and unknown opcodes never act as producers. A load in EX/MEM never forwards, since its data is not yet available.
- R10: Each operand output equals the input named by its select, and select 00 passes the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ex_ir | input | 32 | Instruction word of the consumer in execute |
| ex_mem_ir | input | 32 | Instruction word one slot older |
| mem_wb_ir | input | 32 | Instruction word two slots older |
| rf_a | input | DATA_W | Register-file value for operand A |
| rf_b | input | DATA_W | Register-file value for operand B |
| ex_mem_alu | input | DATA_W | ALU result held in EX/MEM |
| mem_wb_alu | input | DATA_W | ALU result held in MEM/WB |
| mem_wb_load | input | DATA_W | Load data held in MEM/WB |
| sel_a | output | 2 | Operand A select (00 rf, 01 EX/MEM ALU, 10 MEM/WB ALU, 11 MEM/WB load) |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | DATA_W | Operand A to the ALU |
| opnd_b | output | DATA_W | Operand B to the ALU |

## Verification
The bench sweeps every pairing of six opcode classes across the consumer and both producers. It also sweeps register numbers 0, 1 and 31 in every source and destination field, so both destination fields of each producer vary on their own. Several bugs show up as a wrong select or a wrong operand value in those cases: comparing the wrong destination field for a register-register or immediate producer, forwarding from register 0, or letting a store or an EX/MEM load bypass. So do inverting the EX/MEM-over-MEM/WB priority and forwarding operand B for an immediate consumer. Because every data source carries a distinct value, any swapped mux leg also changes the operand value.

// File: rtl/fwd_pkg.sv
// Shared encodings for the operand forwarding unit.
// Assumes 32-bit instruction words with fields numbered big-endian (bit 0 = MSB).
package fwd_pkg;
    localparam int IR_W   = 32;
    localparam int RA_W   = 5;
    localparam int OPC_W  = 6;
    // little-endian MSB of each field, derived from its big-endian start bit
    localparam int OPC_MSB = IR_W - 1 - 0;
    localparam int SRC1_MSB = IR_W - 1 - 6;
    localparam int SRC2_MSB = IR_W - 1 - 11;
    localparam int DRR_MSB  = IR_W - 1 - 16;

    localparam logic [OPC_W-1:0] OPC_RR    = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;
    localparam logic [2:0]       OPC_IMM_HI = 3'b001; // 0x08..0x0F

    typedef enum logic [2:0] {
        CLS_NONE, CLS_RR, CLS_IMM, CLS_LOAD, CLS_STORE, CLS_BRANCH
    } icls_e;

    typedef enum logic [1:0] {
        SEL_RF      = 2'b00,
        SEL_EXM_ALU = 2'b01,
        SEL_WB_ALU  = 2'b10,
        SEL_WB_LOAD = 2'b11
    } fwd_sel_e;
endpackage

// File: rtl/fwd_idecode.sv
// Instruction field decoder for forwarding.
// Classifies one instruction word, extracts its source fields, and reports
// whether and through which field it writes a register. Purely combinational.
module fwd_idecode
    import fwd_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output logic [RA_W-1:0] src1,
    output logic [RA_W-1:0] src2,
    output logic [RA_W-1:0] dest,
    output logic            wr_alu,
    output logic            wr_load,
    output logic            uses_src1,
    output logic            uses_src2
);
    icls_e                 cls;
    logic [OPC_W-1:0]      opc;

    assign opc  = ir[OPC_MSB -: OPC_W];
    assign src1 = ir[SRC1_MSB -: RA_W];
    assign src2 = ir[SRC2_MSB -: RA_W];

    // Map opcode to instruction class
    always_comb begin
        if (opc == OPC_RR)                       cls = CLS_RR;
        else if (opc[5:3] == OPC_IMM_HI)         cls = CLS_IMM;
        else if (opc == OPC_LOAD)                cls = CLS_LOAD;
        else if (opc == OPC_STORE)               cls = CLS_STORE;
        else if (opc == OPC_BEQ || opc == OPC_BNE) cls = CLS_BRANCH;
        else                                     cls = CLS_NONE;
    end

    // Pick the destination field and write kind for this class
    always_comb begin
        dest    = '0;
        wr_alu  = 1'b0;
        wr_load = 1'b0;
        unique case (cls)
            CLS_RR:   begin dest = ir[DRR_MSB -: RA_W];  wr_alu  = 1'b1; end
            CLS_IMM:  begin dest = ir[SRC2_MSB -: RA_W]; wr_alu  = 1'b1; end
            CLS_LOAD: begin dest = ir[SRC2_MSB -: RA_W]; wr_load = 1'b1; end
            default:  ;
        endcase
    end

    assign uses_src1 = (cls != CLS_NONE);
    assign uses_src2 = (cls == CLS_RR);
endmodule

// File: rtl/fwd_srcsel.sv
// Per-operand bypass selector.
// Compares one consumer source field against both producers and returns the
// select, giving the younger EX/MEM producer priority. Register 0 never matches.
module fwd_srcsel
    import fwd_pkg::*;
(
    input  logic [RA_W-1:0] src,
    input  logic            src_used,
    input  logic [RA_W-1:0] exm_dest,
    input  logic            exm_wr_alu,
    input  logic [RA_W-1:0] wb_dest,
    input  logic            wb_wr_alu,
    input  logic            wb_wr_load,
    output fwd_sel_e        sel
);
    logic exm_hit, wb_hit;

    assign exm_hit = src_used && exm_wr_alu && (exm_dest != '0) && (exm_dest == src);
    assign wb_hit  = src_used && (wb_wr_alu || wb_wr_load) && (wb_dest != '0) && (wb_dest == src);

    // Resolve priority between the two producers
    always_comb begin
        if (exm_hit)                 sel = SEL_EXM_ALU;
        else if (wb_hit && wb_wr_load) sel = SEL_WB_LOAD;
        else if (wb_hit)             sel = SEL_WB_ALU;
        else                         sel = SEL_RF;
    end
endmodule

// File: rtl/fwd_opmux.sv
// Four-way operand multiplexer driven by a forwarding select.
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic [DATA_W-1:0] wb_alu,
    input  logic [DATA_W-1:0] wb_load,
    output logic [DATA_W-1:0] opnd
);
    // Route the chosen source to the ALU input
    always_comb begin
        unique case (sel)
            SEL_EXM_ALU: opnd = exm_alu;
            SEL_WB_ALU:  opnd = wb_alu;
            SEL_WB_LOAD: opnd = wb_load;
            default:     opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit_top.sv
// ALU operand forwarding unit (execute stage).
// Decodes the consumer and the two older producers, selects a source per
// operand and drives the multiplexed operands. Combinational: no clock or reset
// is needed since the pipeline registers live outside this block.
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IR_W-1:0]   id_ex_ir,
    input  logic [IR_W-1:0]   ex_mem_ir,
    input  logic [IR_W-1:0]   mem_wb_ir,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] ex_mem_alu,
    input  logic [DATA_W-1:0] mem_wb_alu,
    input  logic [DATA_W-1:0] mem_wb_load,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int N_OPND = 2;

    logic [RA_W-1:0] c_src1, c_src2, c_dest;
    logic            c_wr_alu, c_wr_load, c_use1, c_use2;
    logic [RA_W-1:0] e_src1, e_src2, e_dest;
    logic            e_wr_alu, e_wr_load, e_use1, e_use2;
    logic [RA_W-1:0] w_src1, w_src2, w_dest;
    logic            w_wr_alu, w_wr_load, w_use1, w_use2;

    fwd_idecode u_dec_c (.ir(id_ex_ir), .src1(c_src1), .src2(c_src2), .dest(c_dest),
                         .wr_alu(c_wr_alu), .wr_load(c_wr_load), .uses_src1(c_use1), .uses_src2(c_use2));
    fwd_idecode u_dec_e (.ir(ex_mem_ir), .src1(e_src1), .src2(e_src2), .dest(e_dest),
                         .wr_alu(e_wr_alu), .wr_load(e_wr_load), .uses_src1(e_use1), .uses_src2(e_use2));
    fwd_idecode u_dec_w (.ir(mem_wb_ir), .src1(w_src1), .src2(w_src2), .dest(w_dest),
                         .wr_alu(w_wr_alu), .wr_load(w_wr_load), .uses_src1(w_use1), .uses_src2(w_use2));

    logic [RA_W-1:0]   src_v  [N_OPND];
    logic              used_v [N_OPND];
    logic [DATA_W-1:0] rf_v   [N_OPND];
    fwd_sel_e          sel_v  [N_OPND];
    logic [DATA_W-1:0] opnd_v [N_OPND];

    assign src_v[0]  = c_src1;
    assign used_v[0] = c_use1;
    assign rf_v[0]   = rf_a;
    assign src_v[1]  = c_src2;
    assign used_v[1] = c_use2;
    assign rf_v[1]   = rf_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwd_srcsel u_sel (
            .src(src_v[g]), .src_used(used_v[g]),
            .exm_dest(e_dest), .exm_wr_alu(e_wr_alu),
            .wb_dest(w_dest), .wb_wr_alu(w_wr_alu), .wb_wr_load(w_wr_load),
            .sel(sel_v[g])
        );
        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel_v[g]), .rf_val(rf_v[g]), .exm_alu(ex_mem_alu),
            .wb_alu(mem_wb_alu), .wb_load(mem_wb_load), .opnd(opnd_v[g])
        );
    end

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];

    // Cross-check selects against decoded producers and port data
    always_comb begin
        // R2
        exm_match_chk: assert (sel_a != 2'b01 || (e_dest == id_ex_ir[25:21] && e_dest != '0))
            else $error("operand A took EX/MEM without a matching destination");
        // R9
        exm_no_load_chk: assert ((sel_a != 2'b01 && sel_b != 2'b01) || ex_mem_ir[31:26] != OPC_LOAD)
            else $error("EX/MEM load was forwarded");
        // R5
        wb_load_src_chk: assert ((sel_a != 2'b11 && sel_b != 2'b11) || mem_wb_ir[31:26] == OPC_LOAD)
            else $error("load-data select without a load in MEM/WB");
        // R7
        b_rr_only_chk: assert (sel_b == 2'b00 || id_ex_ir[31:26] == OPC_RR)
            else $error("operand B forwarded for a non register-register consumer");
        // R10
        a_rf_route_chk: assert (sel_a != 2'b00 || opnd_a == rf_a)
            else $error("operand A not routed from register file");
        // R10
        b_rf_route_chk: assert (sel_b != 2'b00 || opnd_b == rf_b)
            else $error("operand B not routed from register file");
    end
endmodule

// File: tb/sim_fwd_unit_top.sv
module sim_fwd_unit_top;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [31:0]   id_ex_ir, ex_mem_ir, mem_wb_ir;
    logic [DW-1:0] rf_a, rf_b, ex_mem_alu, mem_wb_alu, mem_wb_load;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    fwd_unit_top #(.DATA_W(DW)) u0 (
        .id_ex_ir(id_ex_ir), .ex_mem_ir(ex_mem_ir), .mem_wb_ir(mem_wb_ir),
        .rf_a(rf_a), .rf_b(rf_b), .ex_mem_alu(ex_mem_alu),
        .mem_wb_alu(mem_wb_alu), .mem_wb_load(mem_wb_load),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // opcode per class index: RR, IMM, LOAD, STORE, BRANCH, unknown (R1)
    function automatic logic [5:0] opc_of(int k);
        case (k)
            0: return 6'h00; 1: return 6'h0C; 2: return 6'h23;
            3: return 6'h2B; 4: return 6'h04; default: return 6'h3F;
        endcase
    endfunction

    function automatic logic [4:0] reg_of(int k);
        case (k) 0: return 5'd0; 1: return 5'd1; default: return 5'd31; endcase
    endfunction

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] s1, logic [4:0] s2, logic [4:0] d);
        return {op, s1, s2, d, 11'h2A5};
    endfunction

    // producer destination per R3, with a flag for ALU and load writes
    function automatic void prod(input logic [31:0] ir, output logic [4:0] d,
                                 output bit alu, output bit ld);
        logic [5:0] op = ir[31:26];
        alu = 0; ld = 0; d = 0;
        if (op == 6'h00) begin alu = 1; d = ir[15:11]; end
        else if (op >= 6'h08 && op <= 6'h0F) begin alu = 1; d = ir[20:16]; end
        else if (op == 6'h23) begin ld = 1; d = ir[20:16]; end
    endfunction

    function automatic logic [1:0] exp_sel(bit opb, logic [31:0] c, logic [31:0] e, logic [31:0] w);
        logic [5:0] op = c[31:26];
        logic [4:0] s  = opb ? c[20:16] : c[25:21];
        bit known = (op == 6'h00) || (op >= 6'h08 && op <= 6'h0F) || op == 6'h23
                    || op == 6'h2B || op == 6'h04 || op == 6'h05;
        bit used  = opb ? (op == 6'h00) : known;
        logic [4:0] ed, wd; bit ea, el, wa, wl;
        prod(e, ed, ea, el);
        prod(w, wd, wa, wl);
        if (used && ea && ed != 0 && ed == s) return 2'b01;   // R2, R6
        if (used && wl && wd != 0 && wd == s) return 2'b11;   // R5
        if (used && wa && wd != 0 && wd == s) return 2'b10;   // R4
        return 2'b00;                                          // R8, R9
    endfunction

    function automatic logic [DW-1:0] exp_val(logic [1:0] s, logic [DW-1:0] rf);
        case (s)
            2'b01: return ex_mem_alu; 2'b10: return mem_wb_alu;
            2'b11: return mem_wb_load; default: return rf;
        endcase
    endfunction

    function automatic string tag_of(bit opb, logic [1:0] e, logic [31:0] c);
        if (opb && c[31:26] != 6'h00) return "R7";
        case (e) 2'b01: return "R2"; 2'b10: return "R4"; 2'b11: return "R5"; default: return "R8";
        endcase
    endfunction

    // Apply one vector and compare both selects and operands
    task automatic apply(logic [31:0] c, logic [31:0] e, logic [31:0] w, string tag);
        logic [1:0] ea, eb;
        id_ex_ir = c; ex_mem_ir = e; mem_wb_ir = w;
        #1;
        ea = exp_sel(0, c, e, w);
        eb = exp_sel(1, c, e, w);
        n_vec++;
        if (sel_a !== ea || sel_b !== eb) begin
            n_bad++;
            $display("FAIL %s sel: actual a=%b b=%b expected a=%b b=%b (c=%h e=%h w=%h)",
                     (tag != "") ? tag : ((sel_a !== ea) ? tag_of(0, ea, c) : tag_of(1, eb, c)),
                     sel_a, sel_b, ea, eb, c, e, w);
        end else if (opnd_a !== exp_val(ea, rf_a) || opnd_b !== exp_val(eb, rf_b)) begin
            n_bad++;
            $display("FAIL R10 opnd: actual a=%h b=%h expected a=%h b=%h",
                     opnd_a, opnd_b, exp_val(ea, rf_a), exp_val(eb, rf_b));
        end
        #1;
    endtask

    initial begin
        rf_a = 32'hAAAA_0001; rf_b = 32'hBBBB_0002; ex_mem_alu = 32'hE0E0_0003;
        mem_wb_alu = 32'hC0C0_0004; mem_wb_load = 32'hD0D0_0005;
        @(negedge clk);
        // idle: all-zero words are RR ops writing r0 -> register file (R8, R10)
        apply(32'h0, 32'h0, 32'h0, "R8");
        // R1/R3: RR producer writes r7 via bits 16..20; consumer reads r7 in bits 6..10
        apply(mk(6'h00, 5'd7, 5'd3, 5'd9), mk(6'h00, 5'd1, 5'd2, 5'd7), 32'h0, "R3");
        // R3: immediate producer writes via bits 11..15 (r5); rd field r7 must be ignored
        apply(mk(6'h0C, 5'd5, 5'd0, 5'd0), mk(6'h0C, 5'd1, 5'd5, 5'd7), 32'h0, "R3");
        // R6: both producers write r4; EX/MEM wins on both operands
        apply(mk(6'h00, 5'd4, 5'd4, 5'd1), mk(6'h00, 5'd0, 5'd0, 5'd4), mk(6'h23, 5'd0, 5'd4, 5'd0), "R6");
        // R9: store and EX/MEM load never forward
        apply(mk(6'h00, 5'd6, 5'd6, 5'd1), mk(6'h23, 5'd0, 5'd6, 5'd6), mk(6'h2B, 5'd0, 5'd6, 5'd6), "R9");
        // R5: load two slots ahead feeds both operands
        apply(mk(6'h00, 5'd8, 5'd8, 5'd1), mk(6'h04, 5'd0, 5'd8, 5'd8), mk(6'h23, 5'd0, 5'd8, 5'd0), "R5");
        // exhaustive sweep over classes and register numbers {0,1,31}
        for (int cc = 0; cc < 6 && !done; cc++)
          for (int ce = 0; ce < 6; ce++)
            for (int cw = 0; cw < 6; cw++)
              for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                  for (int et = 0; et < 3; et++)
                    for (int ed = 0; ed < 3; ed++)
                      for (int wt = 0; wt < 3; wt++)
                        for (int wd = 0; wd < 3; wd++)
                          apply(mk(opc_of(cc), reg_of(a), reg_of(b), reg_of((a + b) % 3)),
                                mk(opc_of(ce), reg_of(b), reg_of(et), reg_of(ed)),
                                mk(opc_of(cw), reg_of(a), reg_of(wt), reg_of(wd)), "");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a miscompare
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule